// File: doc/BRIEF.md
# Trace comparator access resolver

This block decides what happens when software reads or writes one of the trace address comparator value registers through the system register space. It takes the instruction encoding fields that select the register, a read/write flag, the current exception level, and a set of trap controls and feature-present flags. It returns one outcome:

- perform the access;
- raise an undefined instruction;
- trap to EL1, EL2 or EL3 with a fixed syndrome class;
- halt into debug state.

It also returns the register index selected by the encoding.

Each exception level has its own strict priority chain. The chains mix undefined, trap and halt results. Fine-grained trapping has separate read and write controls. The logic that fetches the instruction and performs the trap entry sits outside the block and consumes the decision. By default the result is registered, so it appears one cycle after the request.

Top module: `tcmp_access_resolver`

## Requirements
- R1: `reg_index` reports the register index formed as {op2[0], crm[3:1]}, a value from 0 to 15.
- R2: An index at or above 2*NUM_PAIRS gives decision 1 (undefined), ahead of every other check.
- R3: Any access with `cur_el` = 0 gives decision 1 (undefined).
- R4: At EL1 the checks are tried in this order, and the first match wins:
  - EL3 present with early-undefined mode and the EL3 trace trap set gives undefined.
  - The EL1 trace trap gives a trap to EL1.
  - EL2 enabled with the EL2 trace trap gives a trap to EL2.
  - An active fine-grained trap gives a trap to EL2.
  - EL3 present with the EL3 trace trap gives undefined when late-undefined mode is set, and a trap to EL3 otherwise.
  - The halt check.
  - Otherwise the access is performed.
- R5: The fine-grained trap is active only when EL2 is enabled, the fine-grained feature is present, and EL3 is either absent or has its fine-grained enable set. A read uses `fg_read_trap` and a write uses `fg_write_trap`.
- R6: At EL2 the EL1 trace trap and the fine-grained checks are skipped. The order is:
  - early undefined (as at EL1);
  - the EL2 trace trap, which traps to EL2 without needing EL2 enabled;
  - the EL3 trace trap (as at EL1);
  - halt;
  - access.
- R7: At EL3 the EL3 trace trap gives a trap to EL3, regardless of the mode bits. Otherwise the halt check runs. Otherwise the access is performed.
- R8: Halt (decision 3) requires all of the following: the external trace buffer is present, the OS lock is clear, halting is allowed, and the debug trace trap is set. At EL2 and EL3 it also requires that EL1 is not in the 32-bit execution state.
- R9: Decision codes are 0 access, 1 undefined, 2 trap and 3 halt.
  - A trap sets `target_el` to the level number (1, 2 or 3) and `syndrome_ec` to 0x18.
  - Every other decision drives both fields to 0.
- R10: With OUT_REG = 1, the results of a request appear on the outputs one cycle after `req_valid`, with `rsp_valid` high for that cycle only. The outputs hold their values while no request arrives. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A decoded access is presented |
| op2 | input | 3 | op2 encoding field |
| crm | input | 4 | CRm encoding field |
| is_write | input | 1 | 1 for a write, 0 for a read |
| cur_el | input | 2 | Current exception level |
| el3_present | input | 1 | EL3 is implemented |
| el2_enabled | input | 1 | EL2 is enabled in the current state |
| fg_present | input | 1 | Fine-grained trap feature present |
| el3_fg_enable | input | 1 | EL3 allows fine-grained traps |
| el3_trace_trap | input | 1 | EL3 trace access trap control |
| el3_undef_early | input | 1 | EL3 trap becomes undefined at highest priority |
| el3_undef_late | input | 1 | EL3 trap becomes undefined instead of a trap to EL3 |
| el2_trace_trap | input | 1 | EL2 trace access trap control |
| el1_trace_trap | input | 1 | EL1 trace access trap control |
| fg_read_trap | input | 1 | Fine-grained trace read trap |
| fg_write_trap | input | 1 | Fine-grained trace write trap |
| tbuf_present | input | 1 | External trace buffer feature present |
| os_lock | input | 1 | OS lock is set |
| halt_allowed | input | 1 | Halting is allowed |
| dbg_trace_trap | input | 1 | Debug trace access halt control |
| el1_narrow | input | 1 | EL1 uses the 32-bit execution state |
| rsp_valid | output | 1 | Result valid |
| decision | output | 3 | 0 access, 1 undefined, 2 trap, 3 halt |
| target_el | output | 2 | Trap target level, 0 when not a trap |
| syndrome_ec | output | 6 | Syndrome class, 0x18 on trap, else 0 |
| reg_index | output | 4 | Selected comparator register |

## Verification
The bench builds the block with NUM_PAIRS = 3 and OUT_REG = 1. The small pair count puts indices 6 to 15 out of range. That brings the out-of-range undefined result within reach from ordinary encodings, including its priority over an EL3 access that would otherwise succeed. Directed vectors walk each level's priority chain one rung at a time. They include the read/write split of the fine-grained trap and the execution-state gate on halt. A long random sweep then compares every result against an independent model.

// File: rtl/tcmp_access_resolver.sv
module tcmp_access_resolver #(
  parameter int NUM_PAIRS = 8,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] op2,
  input  logic [3:0] crm,
  input  logic       is_write,
  input  logic [1:0] cur_el,
  input  logic       el3_present,
  input  logic       el2_enabled,
  input  logic       fg_present,
  input  logic       el3_fg_enable,
  input  logic       el3_trace_trap,
  input  logic       el3_undef_early,
  input  logic       el3_undef_late,
  input  logic       el2_trace_trap,
  input  logic       el1_trace_trap,
  input  logic       fg_read_trap,
  input  logic       fg_write_trap,
  input  logic       tbuf_present,
  input  logic       os_lock,
  input  logic       halt_allowed,
  input  logic       dbg_trace_trap,
  input  logic       el1_narrow,
  output logic       rsp_valid,
  output logic [2:0] decision,
  output logic [1:0] target_el,
  output logic [5:0] syndrome_ec,
  output logic [3:0] reg_index
);

  localparam int         LIMIT   = 2 * NUM_PAIRS;
  localparam logic [5:0] TRAP_EC = 6'h18;
  localparam logic [2:0] D_ACC   = 3'd0;
  localparam logic [2:0] D_UND   = 3'd1;
  localparam logic [2:0] D_TRP   = 3'd2;
  localparam logic [2:0] D_HLT   = 3'd3;

  logic [3:0] idx;
  logic       unused_bits;
  logic       idx_bad;
  logic       early_und;
  logic       el3_hit;
  logic       fg_hit;
  logic       halt_hit;
  logic [2:0] c_dec;
  logic [1:0] c_tgt;
  logic [5:0] c_ec;

  assign idx         = {op2[0], crm[3:1]};
  assign unused_bits = ^{op2[2:1], crm[0]};
  assign idx_bad     = int'(idx) >= LIMIT;
  assign early_und   = el3_present && el3_undef_early && el3_trace_trap;
  assign el3_hit     = el3_present && el3_trace_trap;
  assign fg_hit      = el2_enabled && fg_present && (!el3_present || el3_fg_enable)
                       && (is_write ? fg_write_trap : fg_read_trap);
  assign halt_hit    = tbuf_present && !os_lock && halt_allowed && dbg_trace_trap;

  always_comb begin
    c_dec = D_ACC;
    c_tgt = 2'd0;
    if (idx_bad) begin
      c_dec = D_UND;
    end else begin
      unique case (cur_el)
        2'd0: c_dec = D_UND;
        2'd1: begin
          if (early_und)                          c_dec = D_UND;
          else if (el1_trace_trap)                begin c_dec = D_TRP; c_tgt = 2'd1; end
          else if (el2_enabled && el2_trace_trap) begin c_dec = D_TRP; c_tgt = 2'd2; end
          else if (fg_hit)                        begin c_dec = D_TRP; c_tgt = 2'd2; end
          else if (el3_hit) begin
            if (el3_undef_late) c_dec = D_UND;
            else begin c_dec = D_TRP; c_tgt = 2'd3; end
          end
          else if (halt_hit)                      c_dec = D_HLT;
        end
        2'd2: begin
          if (early_und)           c_dec = D_UND;
          else if (el2_trace_trap) begin c_dec = D_TRP; c_tgt = 2'd2; end
          else if (el3_hit) begin
            if (el3_undef_late) c_dec = D_UND;
            else begin c_dec = D_TRP; c_tgt = 2'd3; end
          end
          else if (halt_hit && !el1_narrow) c_dec = D_HLT;
        end
        default: begin
          if (el3_trace_trap)               begin c_dec = D_TRP; c_tgt = 2'd3; end
          else if (halt_hit && !el1_narrow) c_dec = D_HLT;
        end
      endcase
    end
    c_ec = (c_dec == D_TRP) ? TRAP_EC : 6'd0;
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rsp_valid   <= 1'b0;
          decision    <= D_ACC;
          target_el   <= 2'd0;
          syndrome_ec <= 6'd0;
          reg_index   <= 4'd0;
        end else begin
          rsp_valid <= req_valid;
          if (req_valid) begin
            decision    <= c_dec;
            target_el   <= c_tgt;
            syndrome_ec <= c_ec;
            reg_index   <= idx;
          end
        end
      end
    end else begin : g_comb
      assign rsp_valid   = req_valid;
      assign decision    = c_dec;
      assign target_el   = c_tgt;
      assign syndrome_ec = c_ec;
      assign reg_index   = idx;
    end
  endgenerate

endmodule

module tcmp_access_resolver_chk #(
  parameter int NUM_PAIRS = 8,
  parameter bit OUT_REG   = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] op2,
  input logic [3:0] crm,
  input logic [1:0] cur_el,
  input logic       rsp_valid,
  input logic [2:0] decision,
  input logic [1:0] target_el,
  input logic [5:0] syndrome_ec,
  input logic [3:0] reg_index
);
  logic [3:0] sel;
  logic       over;
  assign sel  = {op2[0], crm[3:1]};
  assign over = int'(sel) >= 2 * NUM_PAIRS;

  // R9
  trap_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && decision == 3'd2 |-> syndrome_ec == 6'h18 && target_el != 2'd0);
  // R9
  nontrap_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && decision != 3'd2 |-> syndrome_ec == 6'd0 && target_el == 2'd0);

  generate
    if (OUT_REG) begin : g_seq
      // R10
      rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
      // R10
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && $stable(decision) && $stable(reg_index));
      // R1
      index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> reg_index == $past(sel));
      // R2
      over_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && over |=> decision == 3'd1);
      // R3
      el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_el == 2'd0 |=> decision == 3'd1);
      // R7
      el3_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_el == 2'd3 |=> !(decision == 3'd2 && target_el != 2'd3));
    end else begin : g_cmb
      // R1
      index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> reg_index == sel);
      // R2
      over_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && over |-> decision == 3'd1);
      // R3
      el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_el == 2'd0 |-> decision == 3'd1);
      // R7
      el3_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_el == 2'd3 |-> !(decision == 3'd2 && target_el != 2'd3));
    end
  endgenerate
endmodule

bind tcmp_access_resolver tcmp_access_resolver_chk #(
  .NUM_PAIRS(NUM_PAIRS), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op2(op2), .crm(crm),
  .cur_el(cur_el), .rsp_valid(rsp_valid), .decision(decision),
  .target_el(target_el), .syndrome_ec(syndrome_ec), .reg_index(reg_index)
);

// File: tb/tcmp_access_resolver_bench.sv
`timescale 1ns/1ps
module tcmp_access_resolver_bench;
  localparam int NP = 3;

  typedef struct packed {
    logic [2:0] op2;
    logic [3:0] crm;
    logic       wr;
    logic [1:0] el;
    logic       el3p, el2en, fgp, el3fg, t3, und_e, und_l, t2, t1, fgr, fgw;
    logic       tbuf, oslk, hok, dbg, narrow;
  } stim_t;

  typedef struct packed {
    logic [2:0] dec;
    logic [1:0] tgt;
    logic [5:0] ec;
    logic [3:0] idx;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  stim_t s = '0;
  logic rsp_valid;
  logic [2:0] decision;
  logic [1:0] target_el;
  logic [5:0] syndrome_ec;
  logic [3:0] reg_index;

  int n_chk = 0;
  int n_bad = 0;
  exp_t  q_e[$];
  string q_t[$];

  always #2.5 clk = ~clk;

  tcmp_access_resolver #(.NUM_PAIRS(NP), .OUT_REG(1'b1)) u_tcmp_access_resolver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op2(s.op2), .crm(s.crm),
    .is_write(s.wr), .cur_el(s.el), .el3_present(s.el3p), .el2_enabled(s.el2en),
    .fg_present(s.fgp), .el3_fg_enable(s.el3fg), .el3_trace_trap(s.t3),
    .el3_undef_early(s.und_e), .el3_undef_late(s.und_l), .el2_trace_trap(s.t2),
    .el1_trace_trap(s.t1), .fg_read_trap(s.fgr), .fg_write_trap(s.fgw),
    .tbuf_present(s.tbuf), .os_lock(s.oslk), .halt_allowed(s.hok),
    .dbg_trace_trap(s.dbg), .el1_narrow(s.narrow), .rsp_valid(rsp_valid),
    .decision(decision), .target_el(target_el), .syndrome_ec(syndrome_ec),
    .reg_index(reg_index)
  );

  function automatic exp_t model(stim_t v);
    exp_t e;
    logic fg, hb;
    e.idx = {v.op2[0], v.crm[3:1]};
    e.dec = 3'd0;
    e.tgt = 2'd0;
    fg = v.el2en && v.fgp && (!v.el3p || v.el3fg) && (v.wr ? v.fgw : v.fgr);
    hb = v.tbuf && !v.oslk && v.hok && v.dbg;
    if (int'(e.idx) >= 2 * NP)  e.dec = 3'd1;
    else if (v.el == 2'd0)      e.dec = 3'd1;
    else if (v.el == 2'd3) begin
      if (v.t3)                 begin e.dec = 3'd2; e.tgt = 2'd3; end
      else if (hb && !v.narrow) e.dec = 3'd3;
    end else begin
      if (v.el3p && v.und_e && v.t3)                     e.dec = 3'd1;
      else if (v.el == 2'd1 && v.t1)                     begin e.dec = 3'd2; e.tgt = 2'd1; end
      else if (v.t2 && (v.el == 2'd2 || v.el2en))        begin e.dec = 3'd2; e.tgt = 2'd2; end
      else if (v.el == 2'd1 && fg)                       begin e.dec = 3'd2; e.tgt = 2'd2; end
      else if (v.el3p && v.t3)                           begin
        if (v.und_l) e.dec = 3'd1; else begin e.dec = 3'd2; e.tgt = 2'd3; end
      end
      else if (hb && (v.el == 2'd1 || !v.narrow))        e.dec = 3'd3;
    end
    e.ec = (e.dec == 3'd2) ? 6'h18 : 6'd0;
    return e;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input stim_t v, input string tag);
    @(negedge clk);
    s = v;
    req_valid = 1'b1;
    q_e.push_back(model(v));
    q_t.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_e.size() == 0) begin
        check(1'b0, "R10 unexpected rsp_valid", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = q_e.pop_front();
        t = q_t.pop_front();
        check({decision, target_el, syndrome_ec, reg_index} == e, t,
              int'({decision, target_el, syndrome_ec, reg_index}), int'(e));
      end
    end
  end

  initial begin
    #900000;
    check(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic stim_t at(input logic [1:0] el);
    stim_t v = '0;
    v.el = el;
    return v;
  endfunction

  initial begin
    stim_t v;
    logic [2:0] held;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && decision == 3'd0 && target_el == 2'd0 && syndrome_ec == 6'd0,
          "R10 reset state", int'({rsp_valid, decision}), 0);
    rst_n = 1'b1;

    v = at(3); v.op2 = 3'b001; v.crm = 4'b0100; drive(v, "R1 index 10");
    v = at(3); v.crm = 4'b0110;                 drive(v, "R1 index 3");
    v = at(3); v.crm = 4'b1100; v.t3 = 1;       drive(v, "R2 index 6 over limit");
    v = at(3); v.crm = 4'b1010;                 drive(v, "R2 index 5 in range");
    v = at(0);                                  drive(v, "R3 EL0");
    v = at(1); v.el3p = 1; v.und_e = 1; v.t3 = 1; v.t1 = 1; drive(v, "R4 early undef");
    v = at(1); v.t1 = 1; v.t2 = 1; v.el2en = 1; drive(v, "R4 EL1 trap");
    v = at(1); v.t2 = 1; v.el3p = 1; v.t3 = 1;  drive(v, "R4 EL2 trap needs enable");
    v = at(1); v.el2en = 1; v.t2 = 1; v.el3p = 1; v.t3 = 1; drive(v, "R4 EL2 trap over EL3");
    v = at(1); v.el3p = 1; v.t3 = 1; v.und_l = 1; drive(v, "R4 late undef");
    v = at(1); v.el2en = 1; v.fgp = 1; v.el3p = 1; v.fgr = 1; drive(v, "R5 fg blocked by EL3");
    v.el3fg = 1;                                drive(v, "R5 fg read trap");
    v.wr = 1;                                   drive(v, "R5 write ignores read bit");
    v.fgw = 1;                                  drive(v, "R5 fg write trap");
    v = at(1); v.tbuf = 1; v.hok = 1; v.dbg = 1; v.narrow = 1; drive(v, "R8 EL1 halt");
    v.el = 2;                                   drive(v, "R8 EL2 narrow no halt");
    v.narrow = 0;                               drive(v, "R8 EL2 halt");
    v.oslk = 1;                                 drive(v, "R8 os lock blocks halt");
    v = at(2); v.t1 = 1; v.el2en = 1; v.fgp = 1; v.fgr = 1; drive(v, "R6 EL2 skips EL1 and fg");
    v = at(2); v.t2 = 1;                        drive(v, "R6 EL2 trap without enable");
    v = at(2); v.t2 = 1; v.el3p = 1; v.und_e = 1; v.t3 = 1; drive(v, "R6 early undef");
    v = at(2); v.el3p = 1; v.t3 = 1;            drive(v, "R9 EL3 trap fields");
    v = at(3); v.t3 = 1; v.und_e = 1; v.und_l = 1; v.el3p = 1; drive(v, "R7 EL3 trap");
    v = at(3); v.t1 = 1; v.t2 = 1; v.el2en = 1; drive(v, "R7 EL3 access");
    v = at(3); v.tbuf = 1; v.hok = 1; v.dbg = 1; drive(v, "R7 EL3 halt");

    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    held = decision;
    v = at(0); s = v;
    repeat (2) @(negedge clk);
    check(rsp_valid == 1'b0 && decision == held, "R10 hold while idle",
          int'(decision), int'(held));

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      string tg;
      r = $urandom;
      v = r[$bits(stim_t)-1:0];
      if (r[31]) v.op2[0] = 1'b0;
      case (v.el)
        2'd0: tg = "R3 random";
        2'd1: tg = "R4 random";
        2'd2: tg = "R6 random";
        default: tg = "R7 random";
      endcase
      drive(v, tg);
    end
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(q_e.size() == 0, "R10 all responses seen", q_e.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule